// File: doc/BRIEF.md
# Output Compare Bank with Master Override

An eight-channel output-compare unit on a free-running 16-bit counter. Each channel compares the counter against its own compare value. On a match it sets a flag and applies a programmed action to its output pin: hold, toggle, clear or set. A pin only follows these actions while its channel is in compare mode and not disconnected. A channel can also toggle its pin when the counter wraps.

There are two extra mechanisms. The first is a force strobe. Writing ones to it fires those channels' pin actions in the same cycle, and no flag is set. The second is a master event on the last channel, which fires on that channel's match or on a counter wrap when its wrap-toggle is enabled. On that event, every channel selected by a mask register copies its bit of a data register onto its pin. This takes priority over the channel's own action.

Software reaches all state through one word-wide register port with a single write strobe and a combinational read path.

Top module: `ocmp_bank`

## Requirements
- R1: After a synchronous active-low reset, all pins, all flags, the counter and every register read back as zero.
- R2: The counter advances by one each cycle and wraps from 0xFFFF to 0x0000. A write to address 0x10 loads it instead of advancing, and reads of 0x10 return the current count.
- R3: A channel matches in a cycle where its compare mode bit is 1 and the counter equals its compare value (addresses 0x00 to 0x07). The flag bit (address 0x0B, bit i for channel i) sets at the next edge. Writing 1 to a flag bit clears it, writing 0 leaves it alone, and a new setting wins over a clear in the same cycle.
- R4: The action field of channel i sits at bits 2i+1:2i of address 0x08. The codes are 00 hold, 01 toggle, 10 drive low and 11 drive high. The action is applied to the pin at the edge that ends the match cycle.
- R5: A write of ones to address 0x0C fires those channels' actions at the edge of that write, and does not set their flags.
- R6: Address 0x0C always reads back zero.
- R7: When a force and a real match land on the same channel in the same cycle, the action is applied once and the flag stays clear.
- R8: The master event occurs on a match of channel 7 or on a counter wrap while wrap-toggle bit 7 (address 0x0F) is set. A wrap is a cycle that holds 0xFFFF with no load.
- R9: On a master event, each channel whose mask bit (address 0x0D) is 1 takes its bit of the data register (address 0x0E) on its pin, overriding its own forced, matched or wrap action.
- R10: A channel whose mask bit is 0 ignores the master event and runs its own action.
- R11: A pin changes only while its mode bit (address 0x09) is 1 and its disconnect bit (address 0x0A) is 0. Otherwise it holds under every kind of event.
- R12: With wrap-toggle bit i set, pin i toggles on a wrap. The toggle gives way to a match or force action on the same edge.
- R13: Mask, data, mode, disconnect, action, wrap-toggle and compare registers read back what was written at any time. Undefined addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| pin_out | output | 8 | Compare output pins |
| flag_out | output | 8 | Per-channel match flags |

## Verification
The bench aims at collisions:
- **Force on the match cycle.** A design that let the match win would raise the flag.
- **Master event on a wrap.** A disconnected masked pin is present, and a design that skipped the enable gate would drive it.
- **Unmasked channels matching on the wrap edge.** A design that applied the override to every channel would lose their own action.
- **Wrap-toggle against a clear action on the same edge.** A design with the wrong priority would leave the pin high.
- **Flag clear while a new match arrives.** A design that let the clear win would drop that match.

Random register traffic places compare values just ahead of the counter, so matches, forces and loads pile up in the same cycles. Every cycle is compared against a bench model.

// File: rtl/ocmp_pkg.sv
// Shared types for the output compare bank: the per-channel action code
// and the function that applies it to a pin level.
package ocmp_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } ocmp_act_e;

    // Returns the pin level after applying action a to current level cur.
    function automatic logic apply_act(input logic cur, input ocmp_act_e a);
        case (a)
            ACT_TOGGLE: return ~cur;
            ACT_CLEAR:  return 1'b0;
            ACT_SET:    return 1'b1;
            default:    return cur;
        endcase
    endfunction

endpackage

// File: rtl/ocmp_counter.sv
// Free-running up counter with a load port.
// Assumes: a load takes the place of the increment in that cycle; wrap
// flags the cycle whose edge takes the count from all ones to zero.
module ocmp_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [CW-1:0] ld_val,
    output logic [CW-1:0] cnt,
    output logic          wrap
);

    // Count register: reset, load or advance.
    always_ff @(posedge clk) begin
        if (!rst_n)  cnt <= '0;
        else if (ld) cnt <= ld_val;
        else         cnt <= cnt + CW'(1);
    end

    // Wrap happens only on a natural rollover, not when a load overrides it.
    assign wrap = (cnt == '1) && !ld;

    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> cnt == $past(cnt) + CW'(1));

    assert_cnt_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> cnt == $past(ld_val));

endmodule

// File: rtl/ocmp_regs.sv
// Register file and read mux of the compare bank.
// Assumes: NCH compare words at addresses 0..NCH-1, then the action,
// mode, disconnect, flag, force, mask, data, wrap-toggle and counter words.
// Force and flag-clear are one-cycle strobes decoded from the write itself.
// 2*NCH must not exceed CW.
module ocmp_regs #(
    parameter int NCH = 8,
    parameter int CW  = 16,
    parameter int AW  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [AW-1:0]     addr,
    input  logic [CW-1:0]     wdata,
    output logic [CW-1:0]     rdata,
    input  logic [NCH-1:0]    flags_in,
    input  logic [CW-1:0]     cnt_in,
    output logic [NCH*CW-1:0] cmp_flat,
    output logic [2*NCH-1:0]  act_v,
    output logic [NCH-1:0]    mode_v,
    output logic [NCH-1:0]    disc_v,
    output logic [NCH-1:0]    mask_v,
    output logic [NCH-1:0]    odata_v,
    output logic [NCH-1:0]    tov_v,
    output logic [NCH-1:0]    force_v,
    output logic [NCH-1:0]    clr_v,
    output logic              cnt_ld
);

    localparam int A_ACT  = NCH;
    localparam int A_MODE = NCH + 1;
    localparam int A_DISC = NCH + 2;
    localparam int A_FLAG = NCH + 3;
    localparam int A_FRC  = NCH + 4;
    localparam int A_MASK = NCH + 5;
    localparam int A_DATA = NCH + 6;
    localparam int A_TOV  = NCH + 7;
    localparam int A_CNT  = NCH + 8;

    logic [CW-1:0] cmp_q [NCH];

    // One write-enabled compare word per channel.
    for (genvar g = 0; g < NCH; g++) begin : g_cmp
        always_ff @(posedge clk) begin
            if (!rst_n)                          cmp_q[g] <= '0;
            else if (wr && addr == AW'(g))       cmp_q[g] <= wdata;
        end
        assign cmp_flat[g*CW +: CW] = cmp_q[g];
    end

    // Control words that hold their value until software rewrites them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_v   <= '0;
            mode_v  <= '0;
            disc_v  <= '0;
            mask_v  <= '0;
            odata_v <= '0;
            tov_v   <= '0;
        end else if (wr) begin
            if (addr == AW'(A_ACT))  act_v   <= wdata[2*NCH-1:0];
            if (addr == AW'(A_MODE)) mode_v  <= wdata[NCH-1:0];
            if (addr == AW'(A_DISC)) disc_v  <= wdata[NCH-1:0];
            if (addr == AW'(A_MASK)) mask_v  <= wdata[NCH-1:0];
            if (addr == AW'(A_DATA)) odata_v <= wdata[NCH-1:0];
            if (addr == AW'(A_TOV))  tov_v   <= wdata[NCH-1:0];
        end
    end

    // Strobes live only in the cycle of the write.
    assign force_v = (wr && addr == AW'(A_FRC))  ? wdata[NCH-1:0] : '0;
    assign clr_v   = (wr && addr == AW'(A_FLAG)) ? wdata[NCH-1:0] : '0;
    assign cnt_ld  = wr && addr == AW'(A_CNT);

    // Read mux; the force word and unused addresses read zero.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCH; i++)
            if (addr == AW'(i)) rdata = cmp_q[i];
        if (addr == AW'(A_ACT))  rdata = CW'(act_v);
        if (addr == AW'(A_MODE)) rdata = CW'(mode_v);
        if (addr == AW'(A_DISC)) rdata = CW'(disc_v);
        if (addr == AW'(A_FLAG)) rdata = CW'(flags_in);
        if (addr == AW'(A_MASK)) rdata = CW'(mask_v);
        if (addr == AW'(A_DATA)) rdata = CW'(odata_v);
        if (addr == AW'(A_TOV))  rdata = CW'(tov_v);
        if (addr == AW'(A_CNT))  rdata = cnt_in;
    end

endmodule

// File: rtl/ocmp_channel.sv
// One compare channel: match detect, flag and pin with its priority chain.
// Assumes: the pin moves only when enabled (mode 1, disconnect 0). Priority
// on an edge is master override, then force or match action, then
// wrap-toggle.
module ocmp_channel
    import ocmp_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cmp,
    input  logic [1:0]    act,
    input  logic          mode,
    input  logic          disc,
    input  logic          force_i,
    input  logic          clr_i,
    input  logic          tov_i,
    input  logic          wrap,
    input  logic          ovr_evt,
    input  logic          mask_i,
    input  logic          odata_i,
    output logic          match_o,
    output logic          pin_o,
    output logic          flag_o
);

    logic en;
    logic pin_q, pin_nxt, flag_q;

    assign en      = mode && !disc;
    assign match_o = mode && (cnt == cmp);

    // Next pin level by priority: override, own action, wrap-toggle, hold.
    always_comb begin
        pin_nxt = pin_q;
        if (en) begin
            if (ovr_evt && mask_i)       pin_nxt = odata_i;
            else if (force_i || match_o) pin_nxt = apply_act(pin_q, ocmp_act_e'(act));
            else if (wrap && tov_i)      pin_nxt = ~pin_q;
        end
    end

    // Pin register.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin_nxt;
    end

    // Flag register: a real unforced match sets, write-one clears.
    always_ff @(posedge clk) begin
        if (!rst_n)                    flag_q <= 1'b0;
        else if (match_o && !force_i)  flag_q <= 1'b1;
        else if (clr_i)                flag_q <= 1'b0;
    end

    assign pin_o  = pin_q;
    assign flag_o = flag_q;

    assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o && !force_i) |=> flag_q);

    assert_flag_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !match_o) |=> !flag_q);

    assert_force_noflag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (force_i && !flag_q) |=> !flag_q);

    assert_override_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_evt && mask_i && en) |=> pin_q == $past(odata_i));

    assert_hold_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> pin_q == $past(pin_q));

endmodule

// File: rtl/ocmp_bank.sv
// Top of the output compare bank: counter, register file, NCH channels
// and the master event taken from the last channel.
// Assumes: the last channel (index NCH-1) is the master; its match or a
// wrap with its wrap-toggle bit set raises the override for all masked
// channels.
module ocmp_bank #(
    parameter  int NCH = 8,
    parameter  int CW  = 16,
    localparam int AW  = $clog2(NCH + 9)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_wr,
    input  logic [AW-1:0]  bus_addr,
    input  logic [CW-1:0]  bus_wdata,
    output logic [CW-1:0]  bus_rdata,
    output logic [NCH-1:0] pin_out,
    output logic [NCH-1:0] flag_out
);

    localparam int MST = NCH - 1;

    logic [CW-1:0]     cnt;
    logic              wrap, cnt_ld, ovr_evt;
    logic [NCH*CW-1:0] cmp_flat;
    logic [2*NCH-1:0]  act_v;
    logic [NCH-1:0]    mode_v, disc_v, mask_v, odata_v, tov_v;
    logic [NCH-1:0]    force_v, clr_v, match_v;

    ocmp_counter #(.CW(CW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (cnt_ld),
        .ld_val (bus_wdata),
        .cnt    (cnt),
        .wrap   (wrap)
    );

    ocmp_regs #(.NCH(NCH), .CW(CW), .AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .flags_in (flag_out),
        .cnt_in   (cnt),
        .cmp_flat (cmp_flat),
        .act_v    (act_v),
        .mode_v   (mode_v),
        .disc_v   (disc_v),
        .mask_v   (mask_v),
        .odata_v  (odata_v),
        .tov_v    (tov_v),
        .force_v  (force_v),
        .clr_v    (clr_v),
        .cnt_ld   (cnt_ld)
    );

    // Master event: last channel matches, or the counter wraps with its wrap-toggle set.
    assign ovr_evt = match_v[MST] || (wrap && tov_v[MST]);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        ocmp_channel #(.CW(CW)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .cnt     (cnt),
            .cmp     (cmp_flat[g*CW +: CW]),
            .act     (act_v[2*g +: 2]),
            .mode    (mode_v[g]),
            .disc    (disc_v[g]),
            .force_i (force_v[g]),
            .clr_i   (clr_v[g]),
            .tov_i   (tov_v[g]),
            .wrap    (wrap),
            .ovr_evt (ovr_evt),
            .mask_i  (mask_v[g]),
            .odata_i (odata_v[g]),
            .match_o (match_v[g]),
            .pin_o   (pin_out[g]),
            .flag_o  (flag_out[g])
        );
    end

endmodule

// File: tb/ocmp_bank_bench.sv
// Bench for ocmp_bank: a cycle model built from the requirements, directed
// collision cases and seeded random register traffic.
module ocmp_bank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [4:0]  addr = 5'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic [7:0]  pin_out, flag_out;

    int total = 0;
    int bad = 0;
    bit mon_on = 1'b0;

    always #10 clk = ~clk;

    ocmp_bank u_ocmp_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (wr),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .pin_out   (pin_out),
        .flag_out  (flag_out)
    );

    // Model state.
    logic [15:0] m_cnt, m_act;
    logic [15:0] m_cmp [8];
    logic [7:0]  m_mode, m_disc, m_mask, m_data, m_tov, m_pin, m_flag;
    logic [7:0]  frc, clr, hit, npin, nflag;
    logic        ld, wrp, ev7;

    // R4: action codes 00 hold, 01 toggle, 10 low, 11 high.
    function automatic logic act_fn(input logic cur, input logic [1:0] c);
        case (c)
            2'b01:   return ~cur;
            2'b10:   return 1'b0;
            2'b11:   return 1'b1;
            default: return cur;
        endcase
    endfunction

    // R13 address map; R6 force word reads zero.
    function automatic logic [15:0] exp_read(input logic [4:0] a);
        if (a < 5'd8) return m_cmp[a[2:0]];
        case (a)
            5'd8:  return m_act;
            5'd9:  return {8'h0, m_mode};
            5'd10: return {8'h0, m_disc};
            5'd11: return {8'h0, m_flag};
            5'd13: return {8'h0, m_mask};
            5'd14: return {8'h0, m_data};
            5'd15: return {8'h0, m_tov};
            5'd16: return m_cnt;
            default: return 16'h0;
        endcase
    endfunction

    // Cycle model advanced at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_act = 0; m_mode = 0; m_disc = 0; m_mask = 0;
            m_data = 0; m_tov = 0; m_pin = 0; m_flag = 0;
            for (int i = 0; i < 8; i++) m_cmp[i] = 0;
        end else begin
            frc = (wr && addr == 5'd12) ? wdata[7:0] : 8'h0;
            clr = (wr && addr == 5'd11) ? wdata[7:0] : 8'h0;
            ld  = wr && addr == 5'd16;
            wrp = (m_cnt == 16'hFFFF) && !ld;
            for (int i = 0; i < 8; i++) hit[i] = m_mode[i] && (m_cnt == m_cmp[i]);
            ev7 = hit[7] || (wrp && m_tov[7]);
            for (int i = 0; i < 8; i++) begin
                npin[i] = m_pin[i];
                if (m_mode[i] && !m_disc[i]) begin
                    if (ev7 && m_mask[i])          npin[i] = m_data[i];
                    else if (frc[i] || hit[i])     npin[i] = act_fn(m_pin[i], m_act[2*i +: 2]);
                    else if (wrp && m_tov[i])      npin[i] = ~m_pin[i];
                end
                nflag[i] = (hit[i] && !frc[i]) ? 1'b1 : (clr[i] ? 1'b0 : m_flag[i]);
            end
            m_pin  = npin;
            m_flag = nflag;
            m_cnt  = ld ? wdata : m_cnt + 16'd1;
            if (wr) begin
                if (addr < 5'd8) m_cmp[addr[2:0]] = wdata;
                case (addr)
                    5'd8:  m_act  = wdata;
                    5'd9:  m_mode = wdata[7:0];
                    5'd10: m_disc = wdata[7:0];
                    5'd13: m_mask = wdata[7:0];
                    5'd14: m_data = wdata[7:0];
                    5'd15: m_tov  = wdata[7:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison, shortly after the falling edge.
    initial forever begin
        @(negedge clk);
        #1;
        if (mon_on) begin
            chk("R4/R9 pins vs model", {8'h0, pin_out}, {8'h0, m_pin});
            chk("R3 flags vs model", {8'h0, flag_out}, {8'h0, m_flag});
            chk("R13 read vs model", rdata, exp_read(addr));
        end
    end

    // Called just after a falling edge; the write lands on the next rising edge.
    task automatic wr_reg(input logic [4:0] a, input logic [15:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic do_reset();
        mon_on = 1'b0;
        @(negedge clk);
        rst_n = 1'b0; wr = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1'b1;
    endtask

    task automatic rand_cycle();
        int r;
        int a;
        r = $urandom_range(0, 99);
        if (r < 60) begin
            wr = 1'b0;
            addr = 5'($urandom_range(0, 18));
        end else begin
            a = (r < 97) ? $urandom_range(0, 15) : 16;
            wr = 1'b1;
            addr = 5'(a);
            if (a < 8)        wdata = m_cnt + 16'($urandom_range(1, 12));
            else if (a == 16) wdata = ($urandom_range(0, 2) == 0) ? 16'hFFF8 : 16'($urandom);
            else if (a == 9)  wdata = 16'($urandom | $urandom);
            else if (a == 10) wdata = 16'($urandom & $urandom & $urandom);
            else              wdata = 16'($urandom);
        end
        @(negedge clk);
    endtask

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd2024);

        // R1: state straight after reset.
        do_reset();
        #1;
        chk("R1 pins after reset", {8'h0, pin_out}, 16'h0);
        chk("R1 flags after reset", {8'h0, flag_out}, 16'h0);
        addr = 5'd13; #1; chk("R1 mask after reset", rdata, 16'h0);
        addr = 5'd14; #1; chk("R1 data after reset", rdata, 16'h0);
        addr = 5'd3;  #1; chk("R1 compare after reset", rdata, 16'h0);
        @(negedge clk);

        // Force, read-back of the force word, force on a match cycle, plain match.
        wr_reg(5'd9, 16'h0003);
        wr_reg(5'd8, 16'h000D);
        wr_reg(5'd0, 16'h0105);
        wr_reg(5'd1, 16'h0100);
        wr_reg(5'd12, 16'h0001);
        #1;
        chk("R5 forced toggle pin0", {15'h0, pin_out[0]}, 16'h1);
        chk("R5 force leaves flag0 clear", {15'h0, flag_out[0]}, 16'h0);
        addr = 5'd12; #1;
        chk("R6 force word reads zero", rdata, 16'h0);
        @(negedge clk);
        wr_reg(5'd16, 16'h0100);
        wr_reg(5'd12, 16'h0002);
        #1;
        chk("R7 force+match pins", {8'h0, pin_out}, 16'h0003);
        chk("R7 force+match flag stays clear", {8'h0, flag_out}, 16'h0000);
        repeat (5) @(posedge clk);
        @(negedge clk); #1;
        chk("R4 match toggles pin0", {8'h0, pin_out}, 16'h0002);
        chk("R3 match sets flag0", {8'h0, flag_out}, 16'h0001);

        // Master event on a wrap with mask, disconnect and priority cases.
        do_reset();
        wr_reg(5'd9,  16'h00FF);
        wr_reg(5'd10, 16'h0001);
        wr_reg(5'd8,  16'h2C20);
        wr_reg(5'd2,  16'hFFFF);
        wr_reg(5'd5,  16'hFFFF);
        wr_reg(5'd6,  16'hFFFF);
        wr_reg(5'd13, 16'h000F);
        wr_reg(5'd14, 16'h0005);
        wr_reg(5'd15, 16'h00C0);
        wr_reg(5'd16, 16'hFFFD);
        addr = 5'd16; #1; chk("R2 counter load", rdata, 16'hFFFD);
        addr = 5'd13; #1; chk("R13 mask readback", rdata, 16'h000F);
        addr = 5'd14; #1; chk("R13 data readback", rdata, 16'h0005);
        repeat (3) @(posedge clk);
        @(negedge clk);
        addr = 5'd16; #1;
        chk("R2 counter wrapped", rdata, 16'h0000);
        chk("R8/R9 masked pin2 takes data", {15'h0, pin_out[2]}, 16'h1);
        chk("R9 masked pins 1,3 take data", {14'h0, pin_out[3], pin_out[1]}, 16'h0);
        chk("R11 disconnected pin0 holds", {15'h0, pin_out[0]}, 16'h0);
        chk("R10 unmasked pin5 runs own set", {15'h0, pin_out[5]}, 16'h1);
        chk("R12 clear beats wrap-toggle pin6", {15'h0, pin_out[6]}, 16'h0);
        chk("R12 wrap-toggle pin7", {15'h0, pin_out[7]}, 16'h1);
        chk("R3 flags after wrap", {8'h0, flag_out}, 16'h0064);
        @(negedge clk);
        addr = 5'd11; wr = 1'b1; wdata = 16'h0004;
        @(posedge clk); @(negedge clk); wr = 1'b0; #1;
        chk("R3 clear with new matches", {8'h0, flag_out}, 16'h00FB);

        // Random traffic.
        do_reset();
        for (int k = 0; k < 3000; k++) rand_cycle();

        mon_on = 1'b0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule